// File: doc/BRIEF.md
# Linked Command Descriptor Loader

This block sets up one channel of a transfer engine from a packed command descriptor held in memory. It fetches a 32-bit header word and treats it as a sparse bitmap: each set bit that has a register assigned to it means that one payload word follows. The loader reads those payload words one at a time and hands each one to an internal register write port, tagged with the number of the header bit it belongs to. When every selected word has been written, it pulses a channel enable. It then waits for the transfer to finish. If the descriptor carried an active link address, the loader continues with the next descriptor.

A descriptor holds at most 16 words, header included. Words are packed: only selected registers occupy a slot. Word k of a descriptor sits at byte address base + 4*k. The read port allows one outstanding request. A request is a single-cycle `mem_req` pulse, and the reply comes back on `mem_rvalid`, with `mem_rerr` marking a failed read.

The controller is a single state machine with these states:
- S_IDLE. Leaves on `start_valid` to S_HDR_REQ.
- S_HDR_REQ. Issues the header read, then moves to S_HDR_WAIT.
- S_HDR_WAIT. On the reply it goes to one of four states: S_ABORT on a read error or an oversize header, S_CLEAR when bit 0 is set, S_PAY_REQ when payload words are selected, and S_ENABLE otherwise.
- S_CLEAR. Moves to S_PAY_REQ, or to S_ENABLE when no payload word is selected.
- S_PAY_REQ. Issues one payload read, then moves to S_PAY_WAIT.
- S_PAY_WAIT. On the reply it goes to S_ABORT on a read error, back to S_PAY_REQ while selected bits remain, and to S_ENABLE after the last word.
- S_ENABLE. Moves to S_RUN.
- S_RUN. On `xfer_done` it goes to S_HDR_REQ when the link is enabled, and to S_IDLE otherwise.
- S_ABORT. Moves to S_IDLE.

Top module: `cmdlink_loader`

## Requirements
- R1: After reset the loader is idle. `busy`, `mem_req`, `reg_we`, `reg_clear`, `ch_enable` and `load_error` are all low.
- R2: A `start_valid` pulse while idle starts a header fetch at `start_addr`. While `busy` is high, `start_valid` is ignored and causes no extra fetch.
- R3: The header bits with a register assigned are 2 to 12, 14, 19, 20, 29, 30 and 31. Each one that is set produces exactly one `reg_we` pulse, with `reg_idx` equal to the bit number and `reg_wdata` equal to the fetched payload word.
- R4: Payload words are consumed in ascending order of their header bit. Word k of a descriptor is read from byte address base + 4*k.
- R5: Header bits 1, 13, 15 to 18 and 21 to 28 are ignored. They cause no write and no fetch.
- R6: Header bit 0 produces one `reg_clear` pulse before any payload word of that descriptor is written. It consumes no payload word.
- R7: After the last payload write of a descriptor, or directly after a header that selects no payload, `ch_enable` pulses once.
- R8: The word for header bit 30 is the link address, and its bit 0 is the link-enable flag. If the flag is set, the next header is fetched on `xfer_done` from that value with bit 0 cleared. If it is clear, or if the descriptor has no bit-30 word, the loader returns to idle. The word for bit 31 is only written as a register.
- R9: A header that selects more than 15 payload words is rejected. The loader pulses `load_error`, returns to idle, writes nothing and does not enable.
- R10: A read error on the header or on any payload word pulses `load_error` and returns the loader to idle. The failed word is not written and `ch_enable` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Request to load a chain beginning at start_addr |
| start_addr | input | ADDR_W | Byte address of the first header |
| busy | output | 1 | High whenever the loader is not idle |
| mem_req | output | 1 | Single-cycle read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rvalid | input | 1 | Read reply valid |
| mem_rdata | input | 32 | Read reply data |
| mem_rerr | input | 1 | Read reply carries an error |
| reg_clear | output | 1 | Pulse requesting a clear of the channel registers |
| reg_we | output | 1 | Register write strobe |
| reg_idx | output | 5 | Header bit number of the register being written |
| reg_wdata | output | 32 | Register write data |
| ch_enable | output | 1 | Pulse enabling the channel after a load |
| xfer_done | input | 1 | The enabled transfer has completed |
| load_error | output | 1 | Pulse on an aborted load |

## Verification
Two events can fall in the same cycle: a read error arriving on the final payload word of a descriptor, and the step to the channel enable that a good reply in that cycle would trigger. The bench provokes this by marking the address of the last payload word as faulty. It then expects one fewer write than the header selects, exactly one `load_error`, and no `ch_enable` at all. The same check is repeated with the fault on a middle word and on the header, so that the abort is judged at every point of the load.

// File: rtl/cmdlink_pkg.sv
package cmdlink_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HDR_REQ,
        S_HDR_WAIT,
        S_CLEAR,
        S_PAY_REQ,
        S_PAY_WAIT,
        S_ENABLE,
        S_RUN,
        S_ABORT
    } ld_state_e;

    localparam int HDR_W = 32;

    // Header bits that own a register slot: 2..12, 14, 19, 20, 29, 30, 31.
    localparam logic [HDR_W-1:0] SLOT_MASK = 32'hE018_5FFC;

    localparam int CLEAR_BIT   = 0;
    localparam int LINK_LO_BIT = 30;

endpackage

// File: rtl/cmdlink_pick.sv
module cmdlink_pick #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    // Lowest set bit wins; scanned from the top so the last hit is the lowest.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/cmdlink_popcount.sv
module cmdlink_popcount #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/cmdlink_loader.sv
module cmdlink_loader
    import cmdlink_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_rerr,
    output logic              reg_clear,
    output logic              reg_we,
    output logic [4:0]        reg_idx,
    output logic [31:0]       reg_wdata,
    output logic              ch_enable,
    input  logic              xfer_done,
    output logic              load_error
);
    localparam int IDX_W      = $clog2(HDR_W);
    localparam int CNT_W      = $clog2(HDR_W + 1);
    localparam int WORD_BYTES = HDR_W / 8;
    localparam logic [CNT_W-1:0] MAX_PAYLOAD = CNT_W'(MAX_WORDS - 1);

    ld_state_e          state_q, state_d;
    logic [ADDR_W-1:0]  addr_q;
    logic [HDR_W-1:0]   pending_q;
    logic [HDR_W-1:0]   hdr_q;
    logic [ADDR_W-1:0]  link_q;
    logic               link_en_q;

    logic [HDR_W-1:0]   hdr_slots;
    logic [CNT_W-1:0]   hdr_cnt;
    logic [IDX_W-1:0]   cur_idx;
    logic [HDR_W-1:0]   pending_next;
    logic               too_long;
    logic               rd_ok;

    assign hdr_slots    = mem_rdata & SLOT_MASK;
    assign pending_next = pending_q & (pending_q - 1'b1);
    assign too_long     = hdr_cnt > MAX_PAYLOAD;
    assign rd_ok        = mem_rvalid && !mem_rerr;

    cmdlink_popcount #(.W(HDR_W), .CW(CNT_W)) u_count (
        .vec (hdr_slots),
        .cnt (hdr_cnt)
    );

    cmdlink_pick #(.W(HDR_W), .IW(IDX_W)) u_pick (
        .vec (pending_q),
        .idx (cur_idx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start_valid) state_d = S_HDR_REQ;
            S_HDR_REQ:  state_d = S_HDR_WAIT;
            S_HDR_WAIT: if (mem_rvalid) begin
                            if (mem_rerr || too_long)    state_d = S_ABORT;
                            else if (mem_rdata[CLEAR_BIT]) state_d = S_CLEAR;
                            else if (hdr_slots != '0)    state_d = S_PAY_REQ;
                            else                         state_d = S_ENABLE;
                        end
            S_CLEAR:    state_d = (pending_q != '0) ? S_PAY_REQ : S_ENABLE;
            S_PAY_REQ:  state_d = S_PAY_WAIT;
            S_PAY_WAIT: if (mem_rvalid) begin
                            if (mem_rerr)                state_d = S_ABORT;
                            else if (pending_next != '0) state_d = S_PAY_REQ;
                            else                         state_d = S_ENABLE;
                        end
            S_ENABLE:   state_d = S_RUN;
            S_RUN:      if (xfer_done) state_d = link_en_q ? S_HDR_REQ : S_IDLE;
            S_ABORT:    state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Fetch address, pending bitmap and link tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            pending_q <= '0;
            hdr_q     <= '0;
            link_q    <= '0;
            link_en_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_valid) addr_q <= start_addr;
                S_HDR_WAIT: if (rd_ok) begin
                    pending_q <= hdr_slots;
                    hdr_q     <= hdr_slots;
                    link_en_q <= 1'b0;
                    addr_q    <= addr_q + ADDR_W'(WORD_BYTES);
                end
                S_PAY_WAIT: if (rd_ok) begin
                    pending_q <= pending_next;
                    addr_q    <= addr_q + ADDR_W'(WORD_BYTES);
                    if (cur_idx == IDX_W'(LINK_LO_BIT)) begin
                        link_q    <= ADDR_W'(mem_rdata) & ~ADDR_W'(1);
                        link_en_q <= mem_rdata[0];
                    end
                end
                S_RUN: if (xfer_done && link_en_q) addr_q <= link_q;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        mem_req    = 1'b0;
        mem_addr   = addr_q;
        reg_clear  = 1'b0;
        reg_we     = 1'b0;
        reg_idx    = cur_idx;
        reg_wdata  = mem_rdata;
        ch_enable  = 1'b0;
        load_error = 1'b0;
        unique case (state_q)
            S_HDR_REQ,
            S_PAY_REQ:  mem_req    = 1'b1;
            S_CLEAR:    reg_clear  = 1'b1;
            S_PAY_WAIT: reg_we     = rd_ok;
            S_ENABLE:   ch_enable  = 1'b1;
            S_ABORT:    load_error = 1'b1;
            default: ;
        endcase
    end

    // A write targets a slot bit that is still pending (R3)
    p_slot_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (SLOT_MASK[reg_idx] && pending_q[reg_idx]));

    // After a write, no pending bit at or below it remains (R4)
    p_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> ((pending_q & ((HDR_W'(1) << (HDR_W'($past(reg_idx)) + 1)) - 1)) == '0));

    // Clear happens before any payload slot is consumed (R6)
    p_clear_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clear |-> (pending_q == hdr_q));

    // Enable only once every selected word is written (R7)
    p_enable_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ch_enable |-> (pending_q == '0));

    // Accepted descriptors stay within the word limit (R9)
    p_len_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PAY_REQ) |-> ($countones(pending_q) <= MAX_WORDS - 1));

    // One outstanding read at a time (R2)
    p_single_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // An abort ends in idle without enabling (R10)
    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_error |=> (!busy && !ch_enable));

endmodule

// File: tb/cmdlink_loader_tb_top.sv
module cmdlink_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] SLOTS = 32'hE018_5FFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic [31:0] start_addr = '0;
    logic        busy, mem_req, reg_clear, reg_we, ch_enable, load_error;
    logic [31:0] mem_addr, reg_wdata;
    logic [4:0]  reg_idx;
    logic        mem_rvalid = 1'b0, mem_rerr = 1'b0, xfer_done = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [256];
    logic [31:0] err_addr = 32'hFFFF_FFFF;

    int checks = 0, errors = 0;
    int act_idx [64]; logic [31:0] act_dat [64]; int n_wr;
    logic [31:0] act_f [64]; int n_f;
    int n_clr, clr_at, n_en, n_err;
    int ex_idx [64]; logic [31:0] ex_dat [64]; int n_ex;
    logic [31:0] ex_f [64]; int n_exf;
    int ex_clr, ex_clr_at, ex_en, ex_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdlink_loader dut_i (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .reg_clear(reg_clear), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .ch_enable(ch_enable),
        .xfer_done(xfer_done), .load_error(load_error)
    );

    // Memory responder: one-cycle latency
    initial begin
        forever begin
            @(posedge clk);
            mem_rvalid <= 1'b0;
            mem_rerr   <= 1'b0;
            if (mem_req) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[9:2]];
                mem_rerr   <= (mem_addr == err_addr);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] hdr,
                            input logic [31:0] link);
        int k = 1;
        mem[base[9:2]] = hdr;
        for (int b = 0; b < 32; b++) begin
            if (SLOTS[b] && hdr[b]) begin
                logic [31:0] a = base + 32'(4 * k);
                if (b == 30) mem[a[9:2]] = link;
                else         mem[a[9:2]] = 32'hD000_0000 | (32'(b) << 16) | {16'h0, a[15:0]};
                k++;
            end
        end
    endtask

    task automatic expect_chain(input logic [31:0] base);
        logic [31:0] cur = base;
        n_ex = 0; n_exf = 0; ex_clr = 0; ex_clr_at = 0; ex_en = 0; ex_err = 0;
        for (int d = 0; d < 4; d++) begin
            logic [31:0] hdr = mem[cur[9:2]];
            logic [31:0] nxt = '0;
            bit lnk = 0;
            int cnt = 0;
            int k = 1;
            ex_f[n_exf++] = cur;
            for (int b = 0; b < 32; b++) if (SLOTS[b] && hdr[b]) cnt++;
            if (cnt > 15) begin ex_err++; break; end
            if (hdr[0]) begin
                if (ex_clr == 0) ex_clr_at = n_ex;
                ex_clr++;
            end
            for (int b = 0; b < 32; b++) begin
                if (SLOTS[b] && hdr[b]) begin
                    logic [31:0] a = cur + 32'(4 * k);
                    ex_f[n_exf++] = a;
                    ex_idx[n_ex] = b;
                    ex_dat[n_ex] = mem[a[9:2]];
                    n_ex++;
                    if (b == 30) begin lnk = mem[a[9:2]][0]; nxt = mem[a[9:2]] & ~32'h1; end
                    k++;
                end
            end
            ex_en++;
            if (!lnk) break;
            cur = nxt;
        end
    endtask

    task automatic run_load(input logic [31:0] base, input bit poke);
        int cd = 0;
        bit done = 0;
        n_wr = 0; n_f = 0; n_clr = 0; clr_at = 0; n_en = 0; n_err = 0;
        @(negedge clk);
        start_valid = 1'b1; start_addr = base;
        @(negedge clk);
        start_valid = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            xfer_done = 1'b0;
            start_valid = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) xfer_done = 1'b1;
                if (poke && cd == 1) begin start_valid = 1'b1; start_addr = 32'h300; end
            end
            if (mem_req) act_f[n_f++ % 64] = mem_addr;
            if (reg_we) begin
                act_idx[n_wr % 64] = int'(reg_idx);
                act_dat[n_wr % 64] = reg_wdata;
                n_wr++;
            end
            if (reg_clear) begin
                if (n_clr == 0) clr_at = n_wr;
                n_clr++;
            end
            if (ch_enable) begin n_en++; cd = 3; end
            if (load_error) n_err++;
            if (!busy) begin done = 1; break; end
            @(negedge clk);
        end
        xfer_done = 1'b0;
        start_valid = 1'b0;
        check(done, "R2", "load did not return to idle", 32'(done), 32'd1);
    endtask

    task automatic compare(input string ctx);
        check(n_wr == n_ex, "R3", {ctx, " write count"}, 32'(n_wr), 32'(n_ex));
        if (n_wr == n_ex)
            for (int i = 0; i < n_ex; i++) begin
                check(act_idx[i] == ex_idx[i], "R4", {ctx, " write order"}, 32'(act_idx[i]), 32'(ex_idx[i]));
                check(act_dat[i] == ex_dat[i], "R3", {ctx, " write data"}, act_dat[i], ex_dat[i]);
            end
        check(n_f == n_exf, "R5", {ctx, " fetch count"}, 32'(n_f), 32'(n_exf));
        if (n_f == n_exf)
            for (int i = 0; i < n_exf; i++)
                check(act_f[i] == ex_f[i], "R4", {ctx, " fetch address"}, act_f[i], ex_f[i]);
        check(n_clr == ex_clr, "R6", {ctx, " clear count"}, 32'(n_clr), 32'(ex_clr));
        if (ex_clr > 0)
            check(clr_at == ex_clr_at, "R6", {ctx, " clear position"}, 32'(clr_at), 32'(ex_clr_at));
        check(n_en == ex_en, "R7", {ctx, " enable count"}, 32'(n_en), 32'(ex_en));
        check(n_err == ex_err, "R10", {ctx, " error count"}, 32'(n_err), 32'(ex_err));
    endtask

    initial begin
        logic [31:0] h;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !mem_req && !reg_we, "R1", "idle outputs in reset", {busy, mem_req, reg_we}, 0);
        check(!reg_clear && !ch_enable && !load_error, "R1", "pulses in reset",
              {reg_clear, ch_enable, load_error}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_req, "R1", "idle after reset release", {busy, mem_req}, 0);

        // R3 R5 R6: every single header bit
        for (int b = 0; b < 32; b++) begin
            put_desc(32'h000, 32'h1 << b, 32'h0);
            expect_chain(32'h000);
            run_load(32'h000, 0);
            compare($sformatf("single bit %0d", b));
        end

        // R3 R4: pseudo-random headers
        h = 32'h1234_5678;
        for (int i = 0; i < 40; i++) begin
            h = h * 32'd1664525 + 32'd1013904223;
            put_desc(32'h080, h & ~32'h8000_0000, 32'h0000_0F00);
            expect_chain(32'h080);
            run_load(32'h080, 0);
            compare($sformatf("random header %0d", i));
        end

        // R9: oversize headers and the largest accepted one
        put_desc(32'h100, SLOTS, 32'h0);
        expect_chain(32'h100);
        check(ex_err == 1, "R9", "bench expects 17-word reject", 32'(ex_err), 32'd1);
        run_load(32'h100, 0);
        compare("R9 seventeen slots");
        put_desc(32'h100, SLOTS & ~32'h8000_0000, 32'h0);
        expect_chain(32'h100);
        run_load(32'h100, 0);
        compare("R9 sixteen slots");
        put_desc(32'h100, (SLOTS & ~32'hC000_0000) | 32'h1, 32'h0);
        expect_chain(32'h100);
        run_load(32'h100, 0);
        compare("R9 fifteen slots accepted");

        // R8: linked chain, link bit 0 set then cleared
        put_desc(32'h200, 32'hC000_0009, 32'h0000_0281);
        put_desc(32'h280, 32'h4000_0060, 32'h0000_0300);
        expect_chain(32'h200);
        check(ex_en == 2, "R8", "bench expects two descriptors", 32'(ex_en), 32'd2);
        run_load(32'h200, 0);
        compare("R8 two-link chain");
        put_desc(32'h200, 32'hC000_0009, 32'h0000_0280);
        expect_chain(32'h200);
        run_load(32'h200, 0);
        compare("R8 link disabled");

        // R10: read errors on header, middle word, last word
        put_desc(32'h180, 32'h0000_001D, 32'h0);
        expect_chain(32'h180);
        err_addr = 32'h180;
        n_ex = 0; n_exf = 1; ex_clr = 0; ex_en = 0; ex_err = 1;
        run_load(32'h180, 0);
        compare("R10 header error");
        expect_chain(32'h180);
        err_addr = 32'h188;
        n_ex = 1; n_exf = 3; ex_en = 0; ex_err = 1;
        run_load(32'h180, 0);
        compare("R10 middle word error");
        expect_chain(32'h180);
        err_addr = 32'h18C;
        n_ex = 2; n_exf = 4; ex_en = 0; ex_err = 1;
        run_load(32'h180, 0);
        compare("R10 last word error");
        err_addr = 32'hFFFF_FFFF;

        // R2: start while busy is ignored
        put_desc(32'h1C0, 32'h0000_0110, 32'h0);
        mem[8'hC0] = 32'h0000_0004;
        expect_chain(32'h1C0);
        run_load(32'h1C0, 1);
        compare("R2 start while busy");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule